// File: doc/BRIEF.md
# Tamper Alarm Supervisor Controller

This controller is the digital core of a security supervisor. It watches four physical tamper lines and two digitized supply-monitor flags, and drives an active-low alarm level that maps onto an open-drain pin (0 means pull low). Lines 1 and 3 rest high and lines 2 and 4 rest low. A supply flag that reports the internal rail above its upper trip point or below its lower trip point counts as a tamper condition in the same way as a tamper line. The alarm does not latch: it releases as soon as every condition has cleared.

Every input passes through a two-flop synchronizer. The tamper lines then pass through a per-line glitch filter that accepts a new level only after it has held for a set number of consecutive cycles. Detection is disarmed after a cold start. It arms only once the main supply has been reported good and a recovery delay has expired. After that it stays armed on main power or on battery, and it disarms only when both sources are gone.

While the alarm is active, a strapped variant select decides the command to the supply-output switch (on, high impedance or ground) and whether the supply-source indicator is forced high. Comparators, references, the switchover circuit and the pads stay outside this block and appear here as digital levels.

Top module: `tamper_supervisor`

## Requirements
- R1: Tamper line bits 0 and 2 signal tamper when low, and bits 1 and 3 signal tamper when high. When armed, a tamper on any single line drives `alarm_n` to 0.
- R2: When armed, `ov_flag` = 1 or `uv_flag` = 1 drives `alarm_n` to 0. Each flag alone is enough.
- R3: The alarm does not latch. `alarm_n` returns to 1 once no line and no flag shows a tamper condition.
- R4: A tamper line level must be seen for HOLD_CYCLES consecutive synchronized cycles before it is accepted. A change shorter than that has no effect on `alarm_n`. A line change reaches `alarm_n` 3+HOLD_CYCLES rising edges after it is applied. A change on a flag, `bat_sel` or `variant` reaches the outputs 3 edges after it is applied.
- R5: After reset, `alarm_n` stays 1 whatever the inputs until `pwr_good` has risen and RECOVERY_CYCLES more cycles have passed. With a tamper condition present, `alarm_n` falls exactly 4+RECOVERY_CYCLES edges after `pwr_good` rises.
- R6: Once armed, detection stays active while `pwr_good` or `bat_present` is 1. It disarms when both are 0, and arming again needs a new `pwr_good` rise plus the full recovery delay.
- R7: `out_mode` encoding: 0 = supply on, 1 = high impedance, 2 = ground. With no alarm it is 0. During an alarm it is 0 for `variant` 0, 1 for `variant` 1, and 2 for `variant` 2 or 3.
- R8: `sw_ind` follows `bat_sel` (0 = main supply, 1 = battery) when there is no alarm or when `variant` is 0. During an alarm with any other `variant` it is forced to 1.
- R9: During and directly after reset, `alarm_n` = 1, `out_mode` = 0 and `sw_ind` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_in | input | 4 | Tamper lines; bits 0 and 2 rest high, bits 1 and 3 rest low |
| ov_flag | input | 1 | Internal rail above the upper trip point |
| uv_flag | input | 1 | Internal rail below the lower trip point |
| pwr_good | input | 1 | Main supply above the reset threshold |
| bat_present | input | 1 | Battery supply present |
| bat_sel | input | 1 | Switchover has selected the battery |
| variant | input | 2 | Strapped alarm-behaviour select |
| alarm_n | output | 1 | Active-low alarm level |
| out_mode | output | 2 | Supply-output command: 0 on, 1 high impedance, 2 ground |
| sw_ind | output | 1 | Supply-source indicator level |

## Verification
A flag, `bat_sel` or `variant` change is due at the outputs after the third rising edge. A tamper-line change is due after edge 3+HOLD_CYCLES. Arming with a condition already present shows up after edge 4+RECOVERY_CYCLES, and disarming shows up after the fourth edge. The directed checks sample one cycle before and exactly at each of these edges. Pulses of HOLD_CYCLES-1 and HOLD_CYCLES cycles are checked for rejection and acceptance. The random phases hold each input pattern for HOLD_CYCLES+6 cycles before they compare, so pipeline depth cannot blur any result.

// File: rtl/tamper_sup_pkg.sv
package tamper_sup_pkg;

  // strap codes
  localparam logic [1:0] VAR_KEEP  = 2'd0;
  localparam logic [1:0] VAR_FLOAT = 2'd1;
  localparam logic [1:0] VAR_SINK  = 2'd2;

  // resting levels of the four tamper lines: bits 0,2 high, bits 1,3 low
  localparam logic [3:0] TP_REST = 4'b0101;

  typedef enum logic [1:0] {
    OM_ON  = 2'd0,
    OM_HIZ = 2'd1,
    OM_GND = 2'd2
  } om_t;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_WAIT = 2'd1,
    ARM_LIVE = 2'd2
  } arm_state_t;

  // output-supply command used while an alarm is active
  function automatic om_t alarm_mode(input logic [1:0] strap);
    case (strap)
      VAR_KEEP:  alarm_mode = OM_ON;
      VAR_FLOAT: alarm_mode = OM_HIZ;
      default:   alarm_mode = OM_GND;
    endcase
  endfunction

  // any line away from its resting level, or either supply flag set
  function automatic logic any_tamper(input logic [3:0] lvl, input logic ov,
                                      input logic uv);
    any_tamper = (|(lvl ^ TP_REST)) | ov | uv;
  endfunction

  // indicator level: forced high during an alarm unless strap keeps normal mode
  function automatic logic sw_level(input logic alarm, input logic [1:0] strap,
                                    input logic on_bat);
    sw_level = (alarm && strap != VAR_KEEP) ? 1'b1 : on_bat;
  endfunction

endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/ts_deglitch.sv
module ts_deglitch #(
  parameter int           W       = 4,
  parameter int           HOLD    = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  for (genvar i = 0; i < W; i++) begin : g_line
    logic          level;
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        level <= RST_VAL[i];
        run   <= '0;
      end else if (d[i] == level) begin
        run <= '0;
      end else if (run == LAST) begin
        level <= d[i];
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end

    assign q[i] = level;
  end
endmodule

// File: rtl/ts_arm.sv
module ts_arm
  import tamper_sup_pkg::*;
#(
  parameter int RECOVERY = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg,
  input  logic bat,
  output logic armed
);
  localparam int CW = (RECOVERY < 2) ? 1 : $clog2(RECOVERY + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOVERY - 1);

  arm_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ARM_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ARM_IDLE: begin
          cnt <= '0;
          if (pg) state <= ARM_WAIT;
        end
        ARM_WAIT: begin
          if (!pg) begin
            state <= ARM_IDLE;
            cnt   <= '0;
          end else if (cnt == LAST) begin
            state <= ARM_LIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ARM_LIVE: begin
          if (!pg && !bat) state <= ARM_IDLE;
        end
        default: state <= ARM_IDLE;
      endcase
    end
  end

  assign armed = (state == ARM_LIVE);
endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor
  import tamper_sup_pkg::*;
#(
  parameter int HOLD_CYCLES     = 4,
  parameter int RECOVERY_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tamper_in,
  input  logic       ov_flag,
  input  logic       uv_flag,
  input  logic       pwr_good,
  input  logic       bat_present,
  input  logic       bat_sel,
  input  logic [1:0] variant,
  output logic       alarm_n,
  output logic [1:0] out_mode,
  output logic       sw_ind
);
  localparam int CTRL_W = 7;

  logic [3:0]        tp_s;
  logic [3:0]        tp_flt;
  logic [CTRL_W-1:0] ctrl_s;
  logic              ov_s, uv_s, pg_s, bat_s, bat_sel_s;
  logic [1:0]        var_s;
  logic              armed_w;
  logic              alarm_req;

  ts_sync #(.W(4), .RST_VAL(TP_REST)) u_tp_sync (
    .clk(clk), .rst_n(rst_n), .d(tamper_in), .q(tp_s)
  );

  ts_sync #(.W(CTRL_W), .RST_VAL('0)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ov_flag, uv_flag, pwr_good, bat_present, bat_sel, variant}),
    .q(ctrl_s)
  );

  assign {ov_s, uv_s, pg_s, bat_s, bat_sel_s, var_s} = ctrl_s;

  ts_deglitch #(.W(4), .HOLD(HOLD_CYCLES), .RST_VAL(TP_REST)) u_filter (
    .clk(clk), .rst_n(rst_n), .d(tp_s), .q(tp_flt)
  );

  ts_arm #(.RECOVERY(RECOVERY_CYCLES)) u_arm (
    .clk(clk), .rst_n(rst_n), .pg(pg_s), .bat(bat_s), .armed(armed_w)
  );

  assign alarm_req = armed_w & any_tamper(tp_flt, ov_s, uv_s);

  om_t  mode_q;
  logic alarm_q;
  logic sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b1;
      mode_q  <= OM_ON;
      sw_q    <= 1'b0;
    end else begin
      alarm_q <= ~alarm_req;
      mode_q  <= alarm_req ? alarm_mode(var_s) : OM_ON;
      sw_q    <= sw_level(alarm_req, var_s, bat_sel_s);
    end
  end

  assign alarm_n  = alarm_q;
  assign out_mode = mode_q;
  assign sw_ind   = sw_q;
endmodule

// File: rtl/ts_checker.sv
module ts_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       alarm_n,
  input logic [1:0] out_mode,
  input logic       sw_ind,
  input logic       armed,
  input logic       pg_s,
  input logic       bat_s,
  input logic       bat_sel_s,
  input logic [1:0] var_s,
  input logic [3:0] tp_s,
  input logic [3:0] tp_flt
);
  // R5: an alarm can only follow a cycle in which detection was armed
  a_r5_alarm_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n |-> $past(armed));

  // R5: arming only completes while power-good is held
  a_r5_arm_with_pg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(pg_s));

  // R6: disarming only when both supplies are gone
  a_r6_disarm_no_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> (!$past(pg_s) && !$past(bat_s)));

  // R4: a filtered line only ever moves to the synchronized level
  a_r4_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ((tp_flt ^ $past(tp_flt)) & (tp_flt ^ $past(tp_s))) == 4'b0);

  // R7: supply stays on without alarm
  a_r7_idle_on: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_n |-> out_mode == 2'd0);

  // R7: alarm mode follows the strap
  a_r7_alarm_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n |-> out_mode == (($past(var_s) == 2'd0) ? 2'd0 :
                              ($past(var_s) == 2'd1) ? 2'd1 : 2'd2));

  // R8: indicator in normal mode
  a_r8_sw_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_n || $past(var_s) == 2'd0) |-> sw_ind == $past(bat_sel_s));

  // R8: indicator forced high
  a_r8_sw_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_n && $past(var_s) != 2'd0) |-> sw_ind);
endmodule

bind tamper_supervisor ts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_n(alarm_n), .out_mode(out_mode),
  .sw_ind(sw_ind), .armed(armed_w), .pg_s(pg_s), .bat_s(bat_s),
  .bat_sel_s(bat_sel_s), .var_s(var_s), .tp_s(tp_s), .tp_flt(tp_flt)
);

// File: tb/tamper_supervisor_test.sv
module tamper_supervisor_test;
  localparam int HOLD = 4;
  localparam int REC  = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tamper_in = 4'b0101;
  logic       ov_flag = 0, uv_flag = 0, pwr_good = 0, bat_present = 0, bat_sel = 0;
  logic [1:0] variant = 2'd0;
  logic       alarm_n, sw_ind;
  logic [1:0] out_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  tamper_supervisor #(.HOLD_CYCLES(HOLD), .RECOVERY_CYCLES(REC)) uut (
    .clk(clk), .rst_n(rst_n), .tamper_in(tamper_in), .ov_flag(ov_flag),
    .uv_flag(uv_flag), .pwr_good(pwr_good), .bat_present(bat_present),
    .bat_sel(bat_sel), .variant(variant), .alarm_n(alarm_n),
    .out_mode(out_mode), .sw_ind(sw_ind)
  );

  // bench model, phrased from the requirements
  function automatic logic m_tamper(logic [3:0] t, logic ov, logic uv);
    return (t[0] == 1'b0) || (t[2] == 1'b0) || t[1] || t[3] || ov || uv;
  endfunction
  function automatic logic [1:0] m_mode(logic alarm, logic [1:0] v);
    if (!alarm) return 2'd0;
    if (v == 2'd0) return 2'd0;
    if (v == 2'd1) return 2'd1;
    return 2'd2;
  endfunction
  function automatic logic m_sw(logic alarm, logic [1:0] v, logic bs);
    if (alarm && v != 2'd0) return 1'b1;
    return bs;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    tick(3);
    check("R9 reset alarm_n", alarm_n, 1);
    check("R9 reset out_mode", out_mode, 0);
    check("R9 reset sw_ind", sw_ind, 0);
    rst_n = 1'b1;
    tick(2);
    check("R9 after reset alarm_n", alarm_n, 1);

    // R5: disarmed with battery only and tamper present
    bat_present = 1;
    ov_flag = 1;
    tamper_in = 4'b0111;
    tick(REC + 20);
    check("R5 not armed before pwr_good", alarm_n, 1);
    tamper_in = 4'b0101;
    tick(HOLD + 6);

    // R5: exact arming edge with ov still set
    pwr_good = 1;
    tick(3 + REC);
    check("R5 one edge before arming", alarm_n, 1);
    tick(1);
    check("R5 arming edge", alarm_n, 0);
    check("R7 variant0 mode on", out_mode, 0);

    // R2 / R3: flag latency of 3 edges
    ov_flag = 0;
    tick(2);
    check("R3 still low before release edge", alarm_n, 0);
    tick(1);
    check("R3 released after flag clear", alarm_n, 1);
    uv_flag = 1;
    tick(3);
    check("R2 uv flag alarms", alarm_n, 0);
    uv_flag = 0;
    tick(3);
    check("R3 uv cleared", alarm_n, 1);

    // R1 / R4: line latency 3+HOLD
    tamper_in = 4'b1101;
    tick(2 + HOLD);
    check("R4 line not yet accepted", alarm_n, 1);
    tick(1);
    check("R1 line 4 high alarms", alarm_n, 0);
    tamper_in = 4'b0101;
    tick(2 + HOLD);
    check("R3 held before release", alarm_n, 0);
    tick(1);
    check("R3 line release", alarm_n, 1);

    // R4: glitch of HOLD-1 rejected
    begin
      logic seen_low;
      seen_low = 0;
      tamper_in = 4'b0100;
      tick(HOLD - 1);
      tamper_in = 4'b0101;
      for (int i = 0; i < HOLD + 8; i++) begin
        tick(1);
        if (!alarm_n) seen_low = 1;
      end
      check("R4 short glitch ignored", seen_low, 0);
      tamper_in = 4'b0100;
      tick(HOLD);
      tamper_in = 4'b0101;
      for (int i = 0; i < HOLD + 8; i++) begin
        tick(1);
        if (!alarm_n) seen_low = 1;
      end
      check("R4 full-length pulse accepted", seen_low, 1);
      tick(HOLD + 4);
      check("R3 after pulse", alarm_n, 1);
    end

    // R7 / R8: directed strap sweep with bat_sel 0
    for (int v = 0; v < 4; v++) begin
      variant = 2'(v);
      ov_flag = 1;
      tick(4);
      check("R7 alarm mode per strap", out_mode, int'(m_mode(1'b1, 2'(v))));
      check("R8 indicator per strap", sw_ind, int'(m_sw(1'b1, 2'(v), 1'b0)));
      ov_flag = 0;
      tick(4);
      check("R7 mode on after alarm", out_mode, 0);
      check("R8 indicator normal", sw_ind, 0);
    end

    // R1 R2 R7 R8: random patterns while armed
    for (int k = 0; k < 300; k++) begin
      logic a;
      if ($urandom_range(0, 2) == 0) tamper_in = 4'b0101;
      else tamper_in = 4'($urandom);
      ov_flag = ($urandom_range(0, 5) == 0);
      uv_flag = ($urandom_range(0, 5) == 0);
      bat_sel = 1'($urandom);
      variant = 2'($urandom);
      bat_present = 1'($urandom);
      tick(HOLD + 6);
      a = m_tamper(tamper_in, ov_flag, uv_flag);
      check("R1 R2 random alarm_n", alarm_n, int'(!a));
      check("R7 random out_mode", out_mode, int'(m_mode(a, variant)));
      check("R8 random sw_ind", sw_ind, int'(m_sw(a, variant, bat_sel)));
    end

    // R6: battery-only keeps detection
    tamper_in = 4'b0101; ov_flag = 0; uv_flag = 0; variant = 2'd0; bat_sel = 1;
    bat_present = 1;
    pwr_good = 0;
    tick(HOLD + 6);
    ov_flag = 1;
    tick(4);
    check("R6 armed on battery", alarm_n, 0);
    check("R8 variant0 shows battery", sw_ind, 1);
    bat_present = 0;
    tick(3);
    check("R6 one edge before disarm shows", alarm_n, 0);
    tick(1);
    check("R6 disarmed with no supply", alarm_n, 1);
    bat_present = 1;
    tick(REC + 10);
    check("R6 battery alone does not rearm", alarm_n, 1);
    pwr_good = 1;
    tick(3 + REC);
    check("R6 rearm waits full delay", alarm_n, 1);
    tick(1);
    check("R6 rearmed after delay", alarm_n, 0);
    ov_flag = 0;
    tick(4);
    check("R3 final release", alarm_n, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule